// File: doc/BRIEF.md
# Prioritized interrupt controller

This block collects up to 32 level-sensitive interrupt lines and decides which one the processor should take next. Each line has an enable flag, a pending flag and a priority value. Software reaches all of them through a small word-addressed register window. Pending flags are set by a rising edge on the line or by a register write. An arbiter finds the most urgent line that is both pending and enabled. That line is shown in a status word as an exception number, which is the line index plus 16, and a request is raised toward the processor.

The processor accepts a request by pulsing an acknowledge input. This clears the winner's pending flag and records the line as the active one. A completion pulse later releases it. While a line is active, a new request is raised only for a pending line whose priority value is strictly lower, which means more urgent. One level of preemption is tracked. A parameter selects whether arbitration is purely combinational or adds a pipeline register.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A write to the enable-set word (0x100) sets the enable of each line whose data bit is 1. A write to the enable-clear word (0x180) clears it. Zero bits have no effect. Reading either word returns the enable flags, bit n for line n.
- R2: The pending-set word (0x200) and the pending-clear word (0x280) behave the same way on the pending flags. Reading either word returns the pending flags.
- R3: Priority words sit at 0x400 + 4*w. Line 4w+k is held in bits 8k+7:8k. Only the top two bits of each byte are stored, and the lower six bits read as 0.
- R4: A 0-to-1 change on irq_in[n] sets pending flag n at the next clock edge. A level held high does not set the flag again after it has been cleared.
- R5: Status word 0x600 bits 17:12 hold 16 + n, where n is the pending and enabled line with the smallest priority value. The field reads 0 when no line is both pending and enabled.
- R6: Among candidate lines with equal priority values, the lowest line number wins.
- R7: Status bit 22 is 1 whenever any pending flag is set, whether or not that line is enabled.
- R8: irq_req_o is high exactly when a winner exists and either no line is active or the winner's priority value is strictly below the active line's.
- R9: An ack_i pulse while irq_req_o is high clears the winner's pending flag and makes that line active. Status bits 5:0 then read 16 + line. An ack_i pulse while irq_req_o is low changes nothing.
- R10: A done_i pulse ends the active state. Status bits 5:0 then read 0.
- R11: After reset, all enables, pending flags, priorities and the active state are 0, and irq_req_o is low.
- R12: When a pending flag is cleared (by a clear write or an acknowledge) in the same cycle that it would be set by an input edge, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_LINES | Level interrupt inputs |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_req_o | output | 1 | Interrupt request to the processor |
| ack_i | input | 1 | Processor accepts the reported line |
| done_i | input | 1 | Handler of the active line finished |

## Verification
A corrupted pending or enable flag shows up immediately in the read-back words and in status bits 17:12 in the same cycle. With the combinational arbiter there is no hidden latency that could mask it. Wrong priority storage or a broken tie rule makes the status word name a different exception number, so the vector table uses tie, masked-bit and disabled-line patterns that each give a unique expected number. A stuck active record shows at the request output: an equally or less urgent pending line must leave irq_req_o low, while a more urgent one must raise it in the cycle after its pending write lands.

// File: rtl/irq_ctl_pkg.sv
`timescale 1ns/1ps
package irq_ctl_pkg;
   localparam logic [11:0] ADR_EN_SET    = 12'h100;
   localparam logic [11:0] ADR_EN_CLR    = 12'h180;
   localparam logic [11:0] ADR_PD_SET    = 12'h200;
   localparam logic [11:0] ADR_PD_CLR    = 12'h280;
   localparam logic [11:0] ADR_PRIO_BASE = 12'h400;
   localparam logic [11:0] ADR_STATUS    = 12'h600;

   localparam int unsigned EXC_W       = 6;
   localparam int unsigned EXC_BASE    = 16;
   localparam int unsigned ST_ACT_LSB  = 0;
   localparam int unsigned ST_WIN_LSB  = 12;
   localparam int unsigned ST_ANY_BIT  = 22;

   typedef struct packed {
      logic set_en;
      logic clr_en;
      logic set_pd;
      logic clr_pd;
      logic prio;
   } wr_strobe_t;
endpackage

// File: rtl/irq_line_bank.sv
`timescale 1ns/1ps
module irq_line_bank
   import irq_ctl_pkg::*;
#(
   parameter int unsigned NUM_LINES = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  wr_strobe_t           wr_stb,
   input  logic [NUM_LINES-1:0] wr_bits,
   input  logic [NUM_LINES-1:0] ack_mask,
   output logic [NUM_LINES-1:0] en_q,
   output logic [NUM_LINES-1:0] pend_q
);
   logic [NUM_LINES-1:0] lvl_q;
   logic [NUM_LINES-1:0] rise;
   logic [NUM_LINES-1:0] en_set, en_clr, pd_set, pd_clr;

   always_comb begin
      rise   = irq_in & ~lvl_q;
      en_set = wr_stb.set_en ? wr_bits : '0;
      en_clr = wr_stb.clr_en ? wr_bits : '0;
      pd_set = (wr_stb.set_pd ? wr_bits : '0) | rise;
      pd_clr = (wr_stb.clr_pd ? wr_bits : '0) | ack_mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q  <= '0;
         en_q   <= '0;
         pend_q <= '0;
      end else begin
         lvl_q  <= irq_in;
         en_q   <= (en_q | en_set) & ~en_clr;
         pend_q <= (pend_q | pd_set) & ~pd_clr;
      end
   end

   assert_rise_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rise & ~pd_clr)) |=> ((pend_q & $past(rise & ~pd_clr)) == $past(rise & ~pd_clr)));

   // covers the acknowledge path of R9 as well
   assert_clear_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (|pd_clr) |=> ((pend_q & $past(pd_clr)) == '0));

   assert_enable_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb.set_en |=> ((en_q & $past(wr_bits)) == $past(wr_bits)));
endmodule

// File: rtl/irq_prio_regs.sv
`timescale 1ns/1ps
module irq_prio_regs #(
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned PRIO_BITS = 2,
   localparam int unsigned NUM_WORDS = (NUM_LINES + 3) / 4,
   localparam int unsigned WORD_AW   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr,
   input  logic [WORD_AW-1:0]                  word_sel,
   input  logic [31:0]                         wdata,
   output logic [31:0]                         rd_data,
   output logic [NUM_LINES-1:0][PRIO_BITS-1:0] prio
);
   logic unused_low_bits;
   assign unused_low_bits = ^wdata;

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      localparam int unsigned WRD  = g / 4;
      localparam int unsigned LANE = g % 4;
      logic [PRIO_BITS-1:0] val_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            val_q <= '0;
         else if (wr && word_sel == WORD_AW'(WRD))
            val_q <= wdata[8*LANE+7 -: PRIO_BITS];
      end
      assign prio[g] = val_q;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (WORD_AW'(i / 4) == word_sel)
            rd_data[8*(i%4)+7 -: PRIO_BITS] = prio[i];
      end
   end

   assert_prio_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(prio));
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
   parameter int unsigned NUM_LINES  = 32,
   parameter int unsigned PRIO_BITS  = 2,
   parameter bit          REGISTERED = 1'b0,
   localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_LINES-1:0]                cand,
   input  logic [NUM_LINES-1:0][PRIO_BITS-1:0] prio,
   output logic                                win_valid,
   output logic [IDX_W-1:0]                    win_idx,
   output logic [PRIO_BITS-1:0]                win_prio
);
   logic                 c_valid;
   logic [IDX_W-1:0]     c_idx;
   logic [PRIO_BITS-1:0] c_prio;

   // strict compare keeps the earliest (lowest) index on ties
   always_comb begin
      c_valid = 1'b0;
      c_idx   = '0;
      c_prio  = '1;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (cand[i] && (!c_valid || prio[i] < c_prio)) begin
            c_valid = 1'b1;
            c_idx   = IDX_W'(i);
            c_prio  = prio[i];
         end
      end
   end

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            win_valid <= 1'b0;
            win_idx   <= '0;
            win_prio  <= '0;
         end else begin
            win_valid <= c_valid;
            win_idx   <= c_idx;
            win_prio  <= c_prio;
         end
      end
   end else begin : g_comb
      assign win_valid = c_valid;
      assign win_idx   = c_idx;
      assign win_prio  = c_prio;

      assert_win_is_cand_R5: assert property (@(posedge clk) disable iff (!rst_n)
         win_valid |-> cand[win_idx]);
      assert_no_win_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (cand == '0) |-> !win_valid);
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl
   import irq_ctl_pkg::*;
#(
   parameter int unsigned NUM_LINES      = 32,
   parameter int unsigned PRIO_BITS      = 2,
   parameter bit          ARB_REGISTERED = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 bus_we,
   input  logic [11:0]          bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   output logic                 irq_req_o,
   input  logic                 ack_i,
   input  logic                 done_i
);
   localparam int unsigned NUM_WORDS = (NUM_LINES + 3) / 4;
   localparam int unsigned WORD_AW   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
   localparam int unsigned IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

   if (NUM_LINES < 2 || NUM_LINES > 32) begin : g_bad_lines
      $error("NUM_LINES must lie in 2..32");
   end
   if (NUM_LINES + EXC_BASE > (1 << EXC_W)) begin : g_bad_exc
      $error("exception numbers overflow the status field");
   end
   if (PRIO_BITS < 1 || PRIO_BITS > 8) begin : g_bad_prio
      $error("PRIO_BITS must lie in 1..8");
   end

   wr_strobe_t                          wr_stb;
   logic [9:0]                          prio_woff;
   logic                                in_prio;
   logic [NUM_LINES-1:0]                en_q, pend_q, ack_mask;
   logic [NUM_LINES-1:0][PRIO_BITS-1:0] prio;
   logic [31:0]                         prio_rd, status_w;
   logic                                win_valid;
   logic [IDX_W-1:0]                    win_idx;
   logic [PRIO_BITS-1:0]                win_prio;
   logic                                act_valid;
   logic [IDX_W-1:0]                    act_idx;
   logic [PRIO_BITS-1:0]                act_prio;
   logic                                ack_fire;

   assign prio_woff = bus_addr[11:2] - ADR_PRIO_BASE[11:2];
   assign in_prio   = (prio_woff < 10'(NUM_WORDS));

   always_comb begin
      wr_stb.set_en = bus_we && (bus_addr == ADR_EN_SET);
      wr_stb.clr_en = bus_we && (bus_addr == ADR_EN_CLR);
      wr_stb.set_pd = bus_we && (bus_addr == ADR_PD_SET);
      wr_stb.clr_pd = bus_we && (bus_addr == ADR_PD_CLR);
      wr_stb.prio   = bus_we && in_prio;
   end

   assign ack_fire = ack_i && irq_req_o;

   always_comb begin
      ack_mask = '0;
      if (ack_fire) ack_mask[win_idx] = 1'b1;
   end

   irq_line_bank #(.NUM_LINES(NUM_LINES)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_in   (irq_in),
      .wr_stb   (wr_stb),
      .wr_bits  (bus_wdata[NUM_LINES-1:0]),
      .ack_mask (ack_mask),
      .en_q     (en_q),
      .pend_q   (pend_q)
   );

   irq_prio_regs #(.NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS)) u_prio (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_stb.prio),
      .word_sel (prio_woff[WORD_AW-1:0]),
      .wdata    (bus_wdata),
      .rd_data  (prio_rd),
      .prio     (prio)
   );

   irq_arbiter #(
      .NUM_LINES (NUM_LINES),
      .PRIO_BITS (PRIO_BITS),
      .REGISTERED(ARB_REGISTERED)
   ) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .cand      (en_q & pend_q),
      .prio      (prio),
      .win_valid (win_valid),
      .win_idx   (win_idx),
      .win_prio  (win_prio)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_valid <= 1'b0;
         act_idx   <= '0;
         act_prio  <= '0;
      end else if (ack_fire) begin
         act_valid <= 1'b1;
         act_idx   <= win_idx;
         act_prio  <= win_prio;
      end else if (done_i) begin
         act_valid <= 1'b0;
      end
   end

   assign irq_req_o = win_valid && (!act_valid || win_prio < act_prio);

   always_comb begin
      status_w = '0;
      if (act_valid)
         status_w[ST_ACT_LSB +: EXC_W] = EXC_W'(EXC_BASE) + EXC_W'(act_idx);
      if (win_valid)
         status_w[ST_WIN_LSB +: EXC_W] = EXC_W'(EXC_BASE) + EXC_W'(win_idx);
      status_w[ST_ANY_BIT] = |pend_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADR_EN_SET || bus_addr == ADR_EN_CLR)
         bus_rdata[NUM_LINES-1:0] = en_q;
      else if (bus_addr == ADR_PD_SET || bus_addr == ADR_PD_CLR)
         bus_rdata[NUM_LINES-1:0] = pend_q;
      else if (in_prio)
         bus_rdata = prio_rd;
      else if (bus_addr == ADR_STATUS)
         bus_rdata = status_w;
   end

   assert_ack_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fire |=> (act_valid && act_idx == $past(win_idx)));

   assert_ack_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !irq_req_o) |=> (act_idx == $past(act_idx)
                                 && act_valid == ($past(act_valid) && !$past(done_i))));

   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !ack_fire) |=> !act_valid);

   if (!ARB_REGISTERED) begin : g_req_chk
      assert_req_has_cand_R8: assert property (@(posedge clk) disable iff (!rst_n)
         irq_req_o |-> (|(en_q & pend_q)));
   end
endmodule

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
   localparam logic [11:0] A_ENS = 12'h100, A_ENC = 12'h180;
   localparam logic [11:0] A_PDS = 12'h200, A_PDC = 12'h280;
   localparam logic [11:0] A_PR0 = 12'h400, A_ST  = 12'h600;

   typedef struct packed {
      logic [31:0] en;
      logic [31:0] pd;
      logic [31:0] p0;
      logic [31:0] p1;
      logic        any;
      logic [5:0]  num;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_00F0, 32'h0000_0030, 32'h0,           32'h0000_4080, 1'b1, 6'd21},
      '{32'hFFFF_FFFF, 32'h8000_0001, 32'h0000_00C0,   32'h0,         1'b1, 6'd47},
      '{32'h0000_00FF, 32'h0000_000C, 32'h4040_0000,   32'h0,         1'b1, 6'd18},
      '{32'h0000_0001, 32'h0000_0100, 32'h0,           32'h0,         1'b1, 6'd0},
      '{32'h0000_000E, 32'h0000_000E, 32'h403F_7F00,   32'h0,         1'b1, 6'd18},
      '{32'h0,         32'h0,         32'h0,           32'h0,         1'b0, 6'd0},
      '{32'h0001_0000, 32'h0001_0000, 32'h0,           32'h0,         1'b1, 6'd32}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_req_o;
   logic        ack_i = 1'b0;
   logic        done_i = 1'b0;

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;

   always #4 clk = ~clk;

   irq_prio_ctrl dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_req_o(irq_req_o), .ack_i(ack_i), .done_i(done_i)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic pulse_ack();
      @(negedge clk); ack_i = 1'b1;
      @(negedge clk); ack_i = 1'b0;
   endtask

   task automatic pulse_done();
      @(negedge clk); done_i = 1'b1;
      @(negedge clk); done_i = 1'b0;
   endtask

   task automatic clear_all();
      wr(A_ENC, 32'hFFFF_FFFF);
      wr(A_PDC, 32'hFFFF_FFFF);
   endtask

   initial begin
      #(8 * 150000);
      if (!ended) begin
         total++; bad++;
         $display("FAIL watchdog got=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      rd(A_ST, d);            check("R11 status", d, 32'h0);
      rd(A_ENS, d);           check("R11 enable", d, 32'h0);
      rd(A_PDS, d);           check("R11 pending", d, 32'h0);
      rd(12'h41C, d);         check("R11 prio", d, 32'h0);
      check("R11 req", {31'b0, irq_req_o}, 32'h0);

      // vector table: R5 R6 R7 R8, with R3 masked priority bits
      for (int i = 0; i < NV; i++) begin
         clear_all();
         wr(A_PR0, VECS[i].p0);
         wr(A_PR0 + 12'h4, VECS[i].p1);
         wr(A_ENS, VECS[i].en);
         wr(A_PDS, VECS[i].pd);
         rd(A_ST, d);
         check("R5 R6 winner", {26'b0, d[17:12]}, {26'b0, VECS[i].num});
         check("R7 any pending", {31'b0, d[22]}, {31'b0, VECS[i].any});
         check("R8 request", {31'b0, irq_req_o}, {31'b0, (VECS[i].num != 6'd0)});
      end
      clear_all();
      wr(A_PR0, 32'h0);
      wr(A_PR0 + 12'h4, 32'h0);

      // R1 enable set/clear
      wr(A_ENS, 32'h5);
      rd(A_ENS, d);           check("R1 set read", d, 32'h5);
      rd(A_ENC, d);           check("R1 clr-word read", d, 32'h5);
      wr(A_ENS, 32'h0);
      rd(A_ENS, d);           check("R1 zero write", d, 32'h5);
      wr(A_ENC, 32'h1);
      rd(A_ENS, d);           check("R1 clear", d, 32'h4);

      // R2 pending set/clear
      wr(A_PDS, 32'h300);
      rd(A_PDC, d);           check("R2 clr-word read", d, 32'h300);
      wr(A_PDC, 32'h100);
      rd(A_PDS, d);           check("R2 clear", d, 32'h200);
      wr(A_PDC, 32'h0);
      rd(A_PDS, d);           check("R2 zero write", d, 32'h200);

      // R3 priority packing
      wr(12'h40C, 32'hFFFF_FFFF);
      rd(12'h40C, d);         check("R3 low bits zero", d, 32'hC0C0_C0C0);
      wr(12'h40C, 32'h1234_5678);
      rd(12'h40C, d);         check("R3 byte lanes", d, 32'h0000_4040);
      rd(12'h408, d);         check("R3 neighbour word", d, 32'h0);
      wr(12'h40C, 32'h0);

      // R4 edge capture
      clear_all();
      wr(A_ENS, 32'h80);
      @(negedge clk); irq_in[7] = 1'b1;
      rd(A_PDS, d);           check("R4 rise sets", d, 32'h80);
      rd(A_ST, d);            check("R4 winner", {26'b0, d[17:12]}, 32'd23);
      wr(A_PDC, 32'h80);
      rd(A_PDS, d);           check("R4 held level", d, 32'h0);
      @(negedge clk); irq_in[7] = 1'b0;
      @(negedge clk); irq_in[7] = 1'b1;
      rd(A_PDS, d);           check("R4 second rise", d, 32'h80);

      // R12 clear beats simultaneous edge
      wr(A_PDC, 32'hFFFF_FFFF);
      @(negedge clk); irq_in[7] = 1'b0;
      @(negedge clk);
      irq_in[7] = 1'b1; bus_we = 1'b1; bus_addr = A_PDC; bus_wdata = 32'h80;
      @(negedge clk); bus_we = 1'b0;
      rd(A_PDS, d);           check("R12 clear wins", d, 32'h0);
      irq_in = '0;

      // R8 R9 R10 active tracking
      clear_all();
      wr(A_PR0, 32'h8000_0000);          // line3 prio 2
      wr(12'h408, 32'h0080_4000);        // line9 prio 1, line10 prio 2
      wr(12'h40C, 32'h0000_00C0);        // line12 prio 3
      wr(A_ENS, 32'hFFFF_FFFF);
      wr(A_PDS, 32'h8);
      rd(A_ST, d);            check("R8 winner line3", {26'b0, d[17:12]}, 32'd19);
      check("R8 req idle", {31'b0, irq_req_o}, 32'h1);
      pulse_ack();
      rd(A_ST, d);            check("R9 active line3", {26'b0, d[5:0]}, 32'd19);
      check("R9 no winner left", {26'b0, d[17:12]}, 32'd0);
      rd(A_PDS, d);           check("R9 pending cleared", d, 32'h0);
      check("R8 req after ack", {31'b0, irq_req_o}, 32'h0);
      wr(A_PDS, 32'h1000);
      rd(A_ST, d);            check("R8 lower urgency shown", {26'b0, d[17:12]}, 32'd28);
      check("R8 lower urgency no req", {31'b0, irq_req_o}, 32'h0);
      wr(A_PDS, 32'h400);
      rd(A_ST, d);            check("R8 equal prio shown", {26'b0, d[17:12]}, 32'd26);
      check("R8 equal prio no req", {31'b0, irq_req_o}, 32'h0);
      wr(A_PDS, 32'h200);
      rd(A_ST, d);            check("R8 preempt shown", {26'b0, d[17:12]}, 32'd25);
      check("R8 preempt req", {31'b0, irq_req_o}, 32'h1);
      pulse_done();
      rd(A_ST, d);            check("R10 active released", {26'b0, d[5:0]}, 32'd0);
      check("R10 req after done", {31'b0, irq_req_o}, 32'h1);
      pulse_ack();
      rd(A_ST, d);            check("R9 active line9", {26'b0, d[5:0]}, 32'd25);
      check("R8 req under line9", {31'b0, irq_req_o}, 32'h0);
      pulse_done();
      rd(A_ST, d);            check("R10 winner line10", {26'b0, d[17:12]}, 32'd26);
      check("R10 req line10", {31'b0, irq_req_o}, 32'h1);
      wr(A_PDC, 32'hFFFF_FFFF);
      check("R8 req none", {31'b0, irq_req_o}, 32'h0);
      pulse_ack();
      rd(A_ST, d);            check("R9 ack ignored", {26'b0, d[5:0]}, 32'd0);

      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule